// File: doc/BRIEF.md
# Supply Source Switchover and Power-On Reset Sequencer

This block picks which supply switch feeds the on-chip regulator and produces the power-on reset for the logic behind that regulator. It works from digital comparator flags. The battery rail gives two flags: one for "below the low switchover level" and one for "above that level plus hysteresis". The regulated rail gives the same pair. Every flag is asynchronous to the block clock, so each one passes through a two-flop synchronizer first.

The battery switch and the charger switch are driven one-hot. A change of source always opens the old switch for one clock before the new switch closes. Reset is raised as soon as the regulated rail reads low. Reset is lowered only after the rail has read high for a continuous number of tick pulses. The tick is prescaled from the low-frequency clock. On the cycle that reset falls, the block issues a one-cycle start pulse that tells downstream logic to load its trim values.

Top module: `supply_seq_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sw_chg_en`=1, `sw_bat_en`=0, `por_out`=1 and `trim_start`=0.
- R2: From the charger source, a high `bat_hi` opens the charger switch at the third clock edge after the input changes, leaving both enables 0 for one cycle. `sw_bat_en` rises at the fourth edge.
- R3: From the battery source, a high `bat_lo` opens the battery switch at the third edge. `sw_chg_en` rises at the fourth edge.
- R4: While both battery flags are 0, the selected source is kept, whichever it is.
- R5: `sw_bat_en` and `sw_chg_en` are never 1 together.
- R6: A high `reg_lo` sets `por_out` to 1 at the third edge after the input changes, whatever the hold count is at that point.
- R7: `por_out` falls at the edge that samples the HOLD_TICKS-th `tick` pulse counted while the synchronized `reg_hi` is 1.
- R8: If the synchronized `reg_hi` reads 0 while reset is still held, the hold count restarts from zero. A full HOLD_TICKS ticks are then needed again, and ticks seen while `reg_hi` is 0 do not count.
- R9: `trim_start` is a one-cycle pulse, high only in the cycle right after `por_out` falls.
- R10: Once reset has been released, both regulated-rail flags reading 0 leaves `por_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle prescaled time-base pulse |
| bat_lo | input | 1 | Battery rail below low switchover level (async) |
| bat_hi | input | 1 | Battery rail above low level plus hysteresis (async) |
| reg_lo | input | 1 | Regulated rail below its low level (async) |
| reg_hi | input | 1 | Regulated rail above low level plus hysteresis (async) |
| sw_bat_en | output | 1 | Battery-path switch enable |
| sw_chg_en | output | 1 | Charger-path switch enable |
| por_out | output | 1 | Power-on reset, active high |
| trim_start | output | 1 | One-cycle trim-load start pulse |

## Verification
A flag change is captured by two synchronizer edges, so its registered result is due at the third edge. The source change completes at the fourth edge, after the one-cycle gap. The bench drives every input on a falling edge. It counts exactly that many falling edges before sampling, and it also samples one edge early, so that a result arriving too soon is caught as well as one arriving too late. Reset release is timed in ticks instead. Each tick is held for one cycle, and `por_out` and `trim_start` are sampled on the falling edge right after the rising edge that consumed that tick.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic [1:0] {
    SRC_CHG     = 2'd0,
    SRC_GAP_BAT = 2'd1,
    SRC_BAT     = 2'd2,
    SRC_GAP_CHG = 2'd3
  } src_state_e;

  localparam int FLAG_BAT_LO = 0;
  localparam int FLAG_BAT_HI = 1;
  localparam int FLAG_REG_LO = 2;
  localparam int FLAG_REG_HI = 3;
  localparam int FLAG_COUNT  = 4;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/src_select.sv
module src_select
  import supply_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bat_lo_s,
  input  logic bat_hi_s,
  output logic sw_bat_en,
  output logic sw_chg_en
);
  src_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      SRC_CHG:     if (bat_hi_s && !bat_lo_s) nxt = SRC_GAP_BAT;
      SRC_GAP_BAT: nxt = SRC_BAT;
      SRC_BAT:     if (bat_lo_s) nxt = SRC_GAP_CHG;
      SRC_GAP_CHG: nxt = SRC_CHG;
      default:     nxt = SRC_CHG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SRC_CHG;
      sw_bat_en <= 1'b0;
      sw_chg_en <= 1'b1;
    end else begin
      state     <= nxt;
      sw_bat_en <= (nxt == SRC_BAT);
      sw_chg_en <= (nxt == SRC_CHG);
    end
  end
endmodule

// File: rtl/por_hold.sv
module por_hold #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic reg_lo_s,
  input  logic reg_hi_s,
  output logic por_out,
  output logic trim_start
);
  localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      por_out    <= 1'b1;
      trim_start <= 1'b0;
    end else begin
      trim_start <= 1'b0;
      if (reg_lo_s) begin
        cnt     <= '0;
        por_out <= 1'b1;
      end else if (por_out) begin
        if (!reg_hi_s) begin
          cnt <= '0;
        end else if (tick) begin
          if (cnt == LAST) begin
            cnt        <= '0;
            por_out    <= 1'b0;
            trim_start <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/supply_seq_top.sv
module supply_seq_top
  import supply_seq_pkg::*;
#(
  parameter int HOLD_TICKS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic bat_lo,
  input  logic bat_hi,
  input  logic reg_lo,
  input  logic reg_hi,
  output logic sw_bat_en,
  output logic sw_chg_en,
  output logic por_out,
  output logic trim_start
);
  logic [FLAG_COUNT-1:0] raw_flags, sync_flags;
  logic bat_lo_s, bat_hi_s, reg_lo_s, reg_hi_s;

  always_comb begin
    raw_flags              = '0;
    raw_flags[FLAG_BAT_LO] = bat_lo;
    raw_flags[FLAG_BAT_HI] = bat_hi;
    raw_flags[FLAG_REG_LO] = reg_lo;
    raw_flags[FLAG_REG_HI] = reg_hi;
  end

  flag_sync #(.WIDTH(FLAG_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_flags), .q(sync_flags)
  );

  assign bat_lo_s = sync_flags[FLAG_BAT_LO];
  assign bat_hi_s = sync_flags[FLAG_BAT_HI];
  assign reg_lo_s = sync_flags[FLAG_REG_LO];
  assign reg_hi_s = sync_flags[FLAG_REG_HI];

  src_select u_src (
    .clk(clk), .rst(rst), .bat_lo_s(bat_lo_s), .bat_hi_s(bat_hi_s),
    .sw_bat_en(sw_bat_en), .sw_chg_en(sw_chg_en)
  );

  por_hold #(.HOLD_TICKS(HOLD_TICKS)) u_por (
    .clk(clk), .rst(rst), .tick(tick), .reg_lo_s(reg_lo_s), .reg_hi_s(reg_hi_s),
    .por_out(por_out), .trim_start(trim_start)
  );
endmodule

// File: rtl/supply_seq_chk.sv
module supply_seq_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic reg_lo_s,
  input logic sw_bat_en,
  input logic sw_chg_en,
  input logic por_out,
  input logic trim_start
);
  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sw_bat_en, sw_chg_en}));

  p_gap_to_bat_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_bat_en) |-> !$past(sw_chg_en));

  p_gap_to_chg_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_chg_en) |-> !$past(sw_bat_en));

  p_lo_forces_reset_r6: assert property (@(posedge clk) disable iff (rst)
    reg_lo_s |=> por_out);

  p_release_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(por_out) |-> $past(tick));

  p_trim_single_r9: assert property (@(posedge clk) disable iff (rst)
    trim_start |=> !trim_start);

  p_trim_at_release_r9: assert property (@(posedge clk) disable iff (rst)
    trim_start |-> (!por_out && $past(por_out)));
endmodule

bind supply_seq_top supply_seq_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .reg_lo_s(reg_lo_s),
  .sw_bat_en(sw_bat_en), .sw_chg_en(sw_chg_en),
  .por_out(por_out), .trim_start(trim_start)
);

// File: tb/sim_supply_seq_top.sv
module sim_supply_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst, tick, bat_lo, bat_hi, reg_lo, reg_hi;
  logic sw_bat_en, sw_chg_en, por_out, trim_start;
  int checks = 0;
  int errors = 0;
  bit both_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_seq_top #(.HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .bat_lo(bat_lo), .bat_hi(bat_hi),
    .reg_lo(reg_lo), .reg_hi(reg_hi), .sw_bat_en(sw_bat_en),
    .sw_chg_en(sw_chg_en), .por_out(por_out), .trim_start(trim_start)
  );

  always @(negedge clk) if (!rst && sw_bat_en && sw_chg_en) both_seen = 1;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; tick = 0; bat_lo = 0; bat_hi = 0; reg_lo = 0; reg_hi = 0;
    cyc(2);
    rst = 0;
  endtask

  task automatic one_tick();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 chg_en", sw_chg_en, 1'b1);
    chk("R1 bat_en", sw_bat_en, 1'b0);
    chk("R1 por", por_out, 1'b1);
    chk("R1 trim", trim_start, 1'b0);
  endtask

  task automatic t_hold_release();
    do_reset();
    reg_hi = 1;
    cyc(3);
    for (int k = 0; k < HOLD - 1; k++) begin
      one_tick();
      chk("R7 held before last tick", por_out, 1'b1);
      chk("R9 no early trim", trim_start, 1'b0);
    end
    one_tick();
    chk("R7 released on last tick", por_out, 1'b0);
    chk("R9 trim pulse", trim_start, 1'b1);
    cyc(1);
    chk("R9 trim one cycle", trim_start, 1'b0);
  endtask

  task automatic t_dip_restart();
    do_reset();
    reg_hi = 1;
    cyc(3);
    one_tick();
    one_tick();
    reg_hi = 0;
    cyc(3);
    one_tick();
    one_tick();
    chk("R8 low-reg ticks ignored", por_out, 1'b1);
    reg_hi = 1;
    cyc(3);
    for (int k = 0; k < HOLD - 1; k++) one_tick();
    chk("R8 count restarted", por_out, 1'b1);
    one_tick();
    chk("R8 release after full hold", por_out, 1'b0);
  endtask

  task automatic t_band_and_lo();
    reg_hi = 0;
    cyc(12);
    chk("R10 band keeps released", por_out, 1'b0);
    chk("R10 no trim in band", trim_start, 1'b0);
    reg_lo = 1;
    cyc(2);
    chk("R6 not before third edge", por_out, 1'b0);
    cyc(1);
    chk("R6 reset on low", por_out, 1'b1);
    reg_lo = 0;
  endtask

  task automatic t_lo_during_count();
    do_reset();
    reg_hi = 1;
    cyc(3);
    one_tick();
    one_tick();
    one_tick();
    reg_lo = 1; reg_hi = 0;
    cyc(3);
    chk("R6 low while counting", por_out, 1'b1);
    reg_lo = 0; reg_hi = 1;
    cyc(3);
    one_tick();
    chk("R8 count cleared by low", por_out, 1'b1);
  endtask

  task automatic t_to_battery();
    do_reset();
    bat_hi = 1;
    cyc(2);
    chk("R2 charger kept before third edge", sw_chg_en, 1'b1);
    cyc(1);
    chk("R2 gap chg off", sw_chg_en, 1'b0);
    chk("R2 gap bat off", sw_bat_en, 1'b0);
    cyc(1);
    chk("R2 battery on", sw_bat_en, 1'b1);
    bat_hi = 0;
    cyc(10);
    chk("R4 battery held in band", sw_bat_en, 1'b1);
    chk("R4 charger off in band", sw_chg_en, 1'b0);
  endtask

  task automatic t_to_charger();
    bat_lo = 1;
    cyc(3);
    chk("R3 gap bat off", sw_bat_en, 1'b0);
    chk("R3 gap chg off", sw_chg_en, 1'b0);
    cyc(1);
    chk("R3 charger on", sw_chg_en, 1'b1);
    bat_lo = 0;
    cyc(10);
    chk("R4 charger held in band", sw_chg_en, 1'b1);
    chk("R4 battery off in band", sw_bat_en, 1'b0);
  endtask

  task automatic t_reset_from_battery();
    bat_hi = 1;
    cyc(5);
    chk("R2 on battery again", sw_bat_en, 1'b1);
    rst = 1;
    cyc(1);
    chk("R1 reset restores charger", sw_chg_en, 1'b1);
    chk("R1 reset clears battery", sw_bat_en, 1'b0);
    rst = 0;
    bat_hi = 0;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
          errors++;
          checks++;
          $display("FAIL watchdog: actual=timeout expected=finish");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none
    rst = 1; tick = 0; bat_lo = 0; bat_hi = 0; reg_lo = 0; reg_hi = 0;
    t_reset_state();
    t_hold_release();
    t_band_and_lo();
    t_dip_restart();
    t_lo_during_count();
    t_to_battery();
    t_to_charger();
    t_reset_from_battery();
    chk("R5 enables never both high", both_seen, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule